// File: doc/BRIEF.md
# B3ZS Bipolar Line Encoder

This block turns a serial stream of binary data bits into a dual-rail bipolar line signal. Each output cycle carries one symbol: a positive pulse, a negative pulse, or no pulse. Ones are sent as pulses of alternating polarity. A run of three zeros would leave the line with no transitions, so every such group is replaced by a pattern that carries a deliberate polarity violation. The receiver can recognise that violation and restore the zeros.

Two substitution patterns exist: "no pulse, no pulse, violation" and "normal pulse, no pulse, violation". The encoder picks between them from the parity of the normal pulses sent since the last violation, so that the number of normal pulses between any two violations is always odd. To make this choice it holds three bits in a look-ahead window. A data bit is accepted only in a cycle where its valid strobe is high. In any other cycle the window and the polarity state are frozen.

Top module: `b3zs_encoder`

## Requirements
- R1: A data one that is not part of a substitution is sent as a pulse whose polarity is opposite to the most recent pulse on either rail.
- R2: No three consecutive data symbols on the line are all empty. Every group of three zeros, scanned from oldest to newest without overlap, is replaced by a substitution pattern.
- R3: When the count of normal pulses sent since the last violation (or since reset) is odd, a group of three zeros is sent as empty, empty, violation.
- R4: When that count is even, a group of three zeros is sent as normal pulse, empty, violation. The normal pulse has the opposite polarity to the most recent pulse.
- R5: A violation pulse has the same polarity as the most recent pulse.
- R6: Between any two violation pulses, and between reset and the first violation, the number of normal (non-violation) pulses is odd.
- R7: The symbol for the bit accepted at the n-th valid cycle appears on the outputs in the cycle after the (n+3)-th valid clock edge. The first three symbols after reset carry no pulse.
- R8: `pos_out` and `neg_out` are never high in the same cycle.
- R9: In the cycle after a clock edge where `in_vld` is low, both outputs are low. The bit on `in_bit` is not accepted, and the encoded stream continues unchanged when valid returns.
- R10: Synchronous reset clears both outputs, sets the most recent polarity to negative and sets the pulse parity to even. The first pulse after reset is therefore positive, and a group of three zeros at the start uses the normal-pulse pattern.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | High when `in_bit` carries a data bit to accept this cycle |
| in_bit | input | 1 | Binary data bit |
| pos_out | output | 1 | Positive-pulse rail, registered |
| neg_out | output | 1 | Negative-pulse rail, registered |

## Verification
A wrong recorded polarity shows up at the next pulse as two pulses of the same sign where alternation was due. A wrong parity bit shows up at the next group of three zeros, where the wrong substitution pattern is chosen. A window that shifts or tags wrongly puts each symbol at the wrong place in the stream, or leaves three empty symbols in a row. The bench feeds every 8-bit pattern back to back, with and without gaps in the valid strobe, and compares each symbol cycle against a reference scan of the same stream. A fault therefore surfaces within a few valid cycles of the point where it arises.

// File: rtl/b3zs_pkg.sv
package b3zs_pkg;

  // Depth of the look-ahead window; the substitution spans this many bits.
  localparam int WIN_LEN = 3;

  // Symbol held in each window stage.
  typedef enum logic [1:0] {
    SYM_ZERO = 2'd0,  // data zero, still eligible for substitution
    SYM_ONE  = 2'd1,  // data one
    SYM_HOLD = 2'd2,  // zero already claimed by a substitution (or fill)
    SYM_VIOL = 2'd3   // violation slot of a substitution
  } sym_t;

  // Tag written into stage 'pos' of the window when a run of zeros is claimed.
  function automatic sym_t subst_tag(input int pos);
    return (pos == 1) ? SYM_VIOL : SYM_HOLD;
  endfunction

  // Even parity of normal pulses since the last violation selects the
  // pattern that starts with a normal pulse.
  function automatic logic pick_lead_pulse(input logic odd_parity);
    return !odd_parity;
  endfunction

  // Polarity of a normal pulse given the polarity of the previous one.
  function automatic logic ami_next(input logic last_positive);
    return !last_positive;
  endfunction

endpackage

// File: rtl/b3zs_window.sv
module b3zs_window
  import b3zs_pkg::*;
#(
  parameter int WIN = WIN_LEN
) (
  input  logic clk,
  input  logic rst,
  input  logic adv,
  input  logic din,
  output sym_t head,
  output logic run_hit
);

  sym_t stg [WIN];

  // A run is claimed only when every stage still holds an unclaimed zero.
  always_comb begin
    run_hit = 1'b1;
    for (int i = 0; i < WIN; i++) begin
      if (stg[i] != SYM_ZERO) run_hit = 1'b0;
    end
  end

  for (genvar i = 0; i < WIN; i++) begin : g_stg
    sym_t nxt;
    sym_t q;
    if (i == 0) begin : g_entry
      assign nxt = din ? SYM_ONE : SYM_ZERO;
    end else begin : g_shift
      assign nxt = run_hit ? subst_tag(i) : stg[i-1];
    end
    always_ff @(posedge clk) begin
      if (rst)      q <= SYM_HOLD;
      else if (adv) q <= nxt;
    end
    assign stg[i] = q;
  end

  assign head = stg[WIN-1];

endmodule

// File: rtl/b3zs_line_state.sv
module b3zs_line_state
  import b3zs_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic adv,
  input  sym_t head,
  input  logic run_hit,
  output logic pos_q,
  output logic neg_q,
  output logic ev_lead,
  output logic ev_viol,
  output logic par_q,
  output logic last_pos_q
);

  logic fire;
  logic pol;

  always_comb begin
    fire    = 1'b0;
    pol     = last_pos_q;
    ev_viol = 1'b0;
    ev_lead = 1'b0;
    if (run_hit) begin
      if (pick_lead_pulse(par_q)) begin
        fire    = 1'b1;
        pol     = ami_next(last_pos_q);
        ev_lead = 1'b1;
      end
    end else begin
      case (head)
        SYM_ONE: begin
          fire = 1'b1;
          pol  = ami_next(last_pos_q);
        end
        SYM_VIOL: begin
          fire    = 1'b1;
          pol     = last_pos_q;
          ev_viol = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q      <= 1'b0;
      neg_q      <= 1'b0;
      par_q      <= 1'b0;
      last_pos_q <= 1'b0;
    end else begin
      pos_q <= adv && fire && pol;
      neg_q <= adv && fire && !pol;
      if (adv && fire) begin
        if (ev_viol) begin
          par_q <= 1'b0;
        end else begin
          last_pos_q <= pol;
          par_q      <= !par_q;
        end
      end
    end
  end

endmodule

// File: rtl/b3zs_encoder.sv
module b3zs_encoder
  import b3zs_pkg::*;
#(
  parameter int WIN = WIN_LEN
) (
  input  logic clk,
  input  logic rst,
  input  logic in_vld,
  input  logic in_bit,
  output logic pos_out,
  output logic neg_out
);

  sym_t head;
  logic run_hit;
  logic ev_lead;
  logic ev_viol;
  logic par_q;
  logic last_pos_q;

  b3zs_window #(.WIN(WIN)) win_i (
    .clk     (clk),
    .rst     (rst),
    .adv     (in_vld),
    .din     (in_bit),
    .head    (head),
    .run_hit (run_hit)
  );

  b3zs_line_state line_i (
    .clk        (clk),
    .rst        (rst),
    .adv        (in_vld),
    .head       (head),
    .run_hit    (run_hit),
    .pos_q      (pos_out),
    .neg_q      (neg_out),
    .ev_lead    (ev_lead),
    .ev_viol    (ev_viol),
    .par_q      (par_q),
    .last_pos_q (last_pos_q)
  );

endmodule

// File: rtl/b3zs_encoder_chk.sv
module b3zs_encoder_chk (
  input logic clk,
  input logic rst,
  input logic in_vld,
  input logic pos_out,
  input logic neg_out,
  input logic ev_viol
);

  // Port-level model of the line: last pulse sign and normal-pulse parity.
  logic       c_last_pos;
  logic       c_par;
  logic       c_vld_q;
  logic [1:0] c_nsym;
  logic [2:0] c_zrun;
  logic       pulse;
  logic       same_sign;

  assign pulse     = pos_out || neg_out;
  assign same_sign = (pos_out && c_last_pos) || (neg_out && !c_last_pos);

  always_ff @(posedge clk) begin
    if (rst) begin
      c_last_pos <= 1'b0;
      c_par      <= 1'b0;
      c_vld_q    <= 1'b0;
      c_nsym     <= '0;
      c_zrun     <= '0;
    end else begin
      c_vld_q <= in_vld;
      if (pulse) begin
        if (same_sign) begin
          c_par <= 1'b0;
        end else begin
          c_par      <= !c_par;
          c_last_pos <= pos_out;
        end
      end
      if (c_vld_q) begin
        if (c_nsym != 2'd3) begin
          c_nsym <= c_nsym + 2'd1;
        end else if (pulse) begin
          c_zrun <= '0;
        end else if (c_zrun != 3'd7) begin
          c_zrun <= c_zrun + 3'd1;
        end
      end
    end
  end

  a_r8_single_rail: assert property (@(posedge clk) disable iff (rst)
    !(pos_out && neg_out));

  a_r9_idle_silent: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> (!pos_out && !neg_out));

  a_r5_viol_repeats: assert property (@(posedge clk) disable iff (rst)
    (ev_viol && in_vld) |=> same_sign);

  a_r6_odd_b: assert property (@(posedge clk) disable iff (rst)
    (pulse && same_sign) |-> c_par);

  a_r2_zero_run: assert property (@(posedge clk) disable iff (rst)
    c_zrun < 3'd3);

endmodule

bind b3zs_encoder b3zs_encoder_chk chk_i (
  .clk     (clk),
  .rst     (rst),
  .in_vld  (in_vld),
  .pos_out (pos_out),
  .neg_out (neg_out),
  .ev_viol (ev_viol)
);

// File: tb/b3zs_encoder_tb_top.sv
module b3zs_encoder_tb_top;

  localparam int NPAT = 256;
  localparam int NB   = NPAT * 8;
  localparam int M    = NB + 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_vld = 1'b0;
  logic in_bit = 1'b0;
  logic pos_out;
  logic neg_out;

  int n_chk = 0;
  int n_bad = 0;
  bit timeout = 0;

  logic bits [M];
  int   exp_s [M];
  int   kind  [M];  // 1 plain zero, 2 one, 3 lead pulse pattern, 4 viol, 5 empty-first pattern

  always #10 clk = ~clk;

  b3zs_encoder dut_i (
    .clk     (clk),
    .rst     (rst),
    .in_vld  (in_vld),
    .in_bit  (in_bit),
    .pos_out (pos_out),
    .neg_out (neg_out)
  );

  function automatic string tag_of(input int k);
    case (k)
      0: return "R7";
      1: return "R2";
      2: return "R1";
      3: return "R4";
      4: return "R5";
      default: return "R3";
    endcase
  endfunction

  task automatic check(input string req, input int got, input int expv);
    n_chk++;
    if (got != expv) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, expv);
    end
  endtask

  // Reference scan: greedy, oldest to newest, polarity +1/-1.
  task automatic build_ref();
    int last = -1;
    int par = 0;
    int i = 0;
    for (int p = 0; p < NPAT; p++)
      for (int b = 0; b < 8; b++) bits[p*8+b] = p[7-b];
    for (int j = NB; j < M; j++) bits[j] = 1'b1;
    while (i < M) begin
      if (i + 2 < M && !bits[i] && !bits[i+1] && !bits[i+2]) begin
        if (par % 2 == 1) begin
          exp_s[i] = 0;     kind[i] = 5;
          exp_s[i+1] = 0;   kind[i+1] = 5;
        end else begin
          last = -last;
          exp_s[i] = last;  kind[i] = 3;
          exp_s[i+1] = 0;   kind[i+1] = 3;
        end
        exp_s[i+2] = last;  kind[i+2] = 4;
        par = 0;
        i += 3;
      end else if (bits[i]) begin
        last = -last;
        exp_s[i] = last; kind[i] = 2;
        par++;
        i++;
      end else begin
        exp_s[i] = 0; kind[i] = 1;
        i++;
      end
    end
  endtask

  task automatic run(input int gaps);
    int vcnt = 0;
    int cyc = 0;
    int b_last = -1;
    int b_cnt = 0;
    @(negedge clk);
    rst = 1'b1; in_vld = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    check("R10", {30'd0, pos_out, neg_out}, 0);
    rst = 1'b0;
    while (vcnt < M) begin
      logic v;
      int got;
      v = !(gaps != 0 && ((cyc % 7 == 3) || (cyc % 11 == 5)));
      in_vld = v;
      in_bit = v ? bits[vcnt] : ~bits[vcnt];
      @(posedge clk);
      #5;
      got = (pos_out && neg_out) ? 2 : pos_out ? 1 : neg_out ? -1 : 0;
      if (pos_out && neg_out) check("R8", got, 0);
      if (v) begin
        int idx = vcnt - 3;
        if (idx < 0) check(tag_of(0), got, 0);
        else check(tag_of(kind[idx]), got, exp_s[idx]);
        vcnt++;
      end else begin
        check("R9", got, 0);
      end
      // R6: observed normal pulses between violations must be odd
      if (got == 1 || got == -1) begin
        if (got == b_last) begin
          check("R6", b_cnt % 2, 1);
          b_cnt = 0;
        end else begin
          b_cnt++;
          b_last = got;
        end
      end
      cyc++;
      @(negedge clk);
    end
    in_vld = 1'b0;
  endtask

  initial begin
    build_ref();
    fork
      begin
        run(0);
        run(1);
      end
      begin
        repeat (200000) @(posedge clk);
        timeout = 1;
      end
    join_any
    disable fork;
    if (timeout) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule